// File: doc/BRIEF.md
# Battery-Backed RAM Access Guard

This block sits between a register-bus access port and a 256-byte battery-backed RAM. The RAM is organised as two 128-byte banks, selected by one bank bit and addressed by a 7-bit index. For each access, the guard decides whether it may reach the RAM. The decision comes from a 32-bit configuration register that holds three live fields: a switch that opens the upper bank, and two sticky protection bits, one per bank. Each protection bit fences off the eight bytes at indices 38h through 3Fh of its own bank.

A permitted write asserts the RAM write strobe in the same cycle, with address `{bank, index}`. A refused write never strobes the RAM and gives no indication that it was dropped. Every read request produces a completion pulse exactly one cycle later. A permitted read returns the RAM byte with the valid flag high. A refused read returns FFh with the valid flag low. Once a protection bit has been set, software cannot clear it. Only the synchronous reset returns it to 0.

Top module: `rtcl_ram_guard`

## Requirements
- R1: After reset, the configuration register reads 00000000h, `rd_valid` and `rd_done` are 0, and `rd_data` is FFh.
- R2: Configuration bits 31:5 and 1:0 always read 0, whatever value is written to them.
- R3: While configuration bit 3 is 1, a write to the lower bank (bank=0) at any index from 38h to 3Fh does not assert `ram_we`. A read there completes with `rd_valid`=0 and `rd_data`=FFh.
- R4: While configuration bit 4 is 1, a write to the upper bank (bank=1) at any index from 38h to 3Fh does not assert `ram_we`. A read there completes with `rd_valid`=0 and `rd_data`=FFh.
- R5: Bits 4 and 3 are set by writing 1. Writing 0 to a bit that is already set leaves it at 1. Only reset clears these bits.
- R6: While configuration bit 2 is 0, every upper-bank write at any index is dropped. Every upper-bank read completes with `rd_valid`=0 and `rd_data`=FFh.
- R7: Configuration bit 2 follows each configuration write in both directions, even while a protection bit is set.
- R8: A permitted write drives `ram_we`=1, `ram_addr`={bank,index} and `ram_wdata` in the cycle of the request. A permitted read returns the RAM byte at {bank,index} on `rd_data`, with `rd_valid`=1, one cycle after the request.
- R9: A protection bit affects only its own bank and only indices 38h to 3Fh. Neighbouring indices such as 37h and 40h, and the same window in the other bank, still pass through.
- R10: `rd_done` is 1 exactly in the cycle after each read request and 0 otherwise. Whenever `rd_valid` is 0, `rd_data` is FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Current configuration register value |
| acc_req | input | 1 | Access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_bank | input | 1 | 0 = lower bank, 1 = upper bank |
| acc_index | input | 7 | Byte index within the bank |
| acc_wdata | input | 8 | Write data |
| ram_we | output | 1 | Gated RAM write strobe |
| ram_addr | output | 8 | RAM address {bank,index} |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | Combinational RAM read data for ram_addr |
| rd_data | output | 8 | Read result, FFh when not valid |
| rd_valid | output | 1 | Read result is genuine RAM data |
| rd_done | output | 1 | A read completed this cycle |

## Verification
The assertions check the following on every cycle:
- `ram_we` never fires into a protected window or into a disabled upper bank.
- The protection bits never fall except under reset.
- The reserved bits stay at 0.
- Each read request is followed one cycle later by a completion pulse.
- Invalid read data is always FFh.

Some properties can only be shown by the bench's scenarios. These include the following:
- Dropped writes really left the RAM contents unchanged. The bench shows this by reading the window back after a reset.
- Passthrough returns the correct byte.
- Neighbouring indices and the other bank stay open while a window is fenced.

// File: rtl/rtcl_pkg.sv
package rtcl_pkg;
    localparam int CFG_W   = 32;
    localparam int IDX_W   = 7;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = IDX_W + 1;

    // Field positions inside the configuration word
    localparam int POS_UPPER_LOCK = 4;
    localparam int POS_LOWER_LOCK = 3;
    localparam int POS_UPPER_EN   = 2;

    // Protected window: indices WIN_BASE .. WIN_BASE + 2**WIN_LG - 1
    localparam logic [IDX_W-1:0] WIN_BASE = 7'h38;
    localparam int               WIN_LG   = 3;

    localparam logic [DATA_W-1:0] FILL_BYTE = 8'hFF;

    typedef struct packed {
        logic upper_lock;
        logic lower_lock;
        logic upper_en;
    } cfg_t;

    typedef struct packed {
        logic              req;
        logic              wr;
        logic              bank;
        logic [IDX_W-1:0]  index;
        logic [DATA_W-1:0] wdata;
    } acc_t;

    typedef struct packed {
        logic allow;
        logic in_window;
        logic bank_fenced;
        logic bank_off;
    } verdict_t;

    function automatic logic in_window(input logic [IDX_W-1:0] idx);
        return (idx >> WIN_LG) == (WIN_BASE >> WIN_LG);
    endfunction

    function automatic logic [CFG_W-1:0] pack_cfg(input cfg_t c);
        logic [CFG_W-1:0] w;
        w = '0;
        w[POS_UPPER_LOCK] = c.upper_lock;
        w[POS_LOWER_LOCK] = c.lower_lock;
        w[POS_UPPER_EN]   = c.upper_en;
        return w;
    endfunction
endpackage

// File: rtl/rtcl_cfg_reg.sv
module rtcl_cfg_reg
    import rtcl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg,
    output logic [CFG_W-1:0] rdata
);
    cfg_t cfg_q;
    logic unused_wbits;

    assign unused_wbits = ^{wdata[CFG_W-1:POS_UPPER_LOCK+1], wdata[POS_UPPER_EN-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            // protection bits only accumulate; the enable follows the write
            cfg_q.upper_lock <= cfg_q.upper_lock | wdata[POS_UPPER_LOCK];
            cfg_q.lower_lock <= cfg_q.lower_lock | wdata[POS_LOWER_LOCK];
            cfg_q.upper_en   <= wdata[POS_UPPER_EN];
        end
    end

    assign cfg   = cfg_q;
    assign rdata = pack_cfg(cfg_q);
endmodule

// File: rtl/rtcl_policy.sv
module rtcl_policy
    import rtcl_pkg::*;
(
    input  cfg_t     cfg,
    input  acc_t     acc,
    output verdict_t verdict
);
    always_comb begin
        verdict.in_window   = in_window(acc.index);
        verdict.bank_off    = acc.bank && !cfg.upper_en;
        verdict.bank_fenced = verdict.in_window &&
                              (acc.bank ? cfg.upper_lock : cfg.lower_lock);
        verdict.allow       = !verdict.bank_off && !verdict.bank_fenced;
    end
endmodule

// File: rtl/rtcl_rd_stage.sv
module rtcl_rd_stage
    import rtcl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic              allow,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_done  <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= FILL_BYTE;
        end else begin
            rd_done  <= rd_req;
            rd_valid <= rd_req && allow;
            rd_data  <= (rd_req && allow) ? ram_rdata : FILL_BYTE;
        end
    end
endmodule

// File: rtl/rtcl_ram_guard.sv
module rtcl_ram_guard
    import rtcl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              acc_req,
    input  logic              acc_write,
    input  logic              acc_bank,
    input  logic [IDX_W-1:0]  acc_index,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_done
);
    cfg_t     cfg;
    acc_t     acc;
    verdict_t verdict;

    assign acc = '{req: acc_req, wr: acc_write, bank: acc_bank,
                   index: acc_index, wdata: acc_wdata};

    rtcl_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    rtcl_policy u_policy (
        .cfg     (cfg),
        .acc     (acc),
        .verdict (verdict)
    );

    assign ram_addr  = {acc.bank, acc.index};
    assign ram_wdata = acc.wdata;
    assign ram_we    = acc.req && acc.wr && verdict.allow;

    rtcl_rd_stage u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_req    (acc.req && !acc.wr),
        .allow     (verdict.allow),
        .ram_rdata (ram_rdata),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .rd_done   (rd_done)
    );
endmodule

// File: rtl/rtcl_guard_checker.sv
module rtcl_guard_checker
    import rtcl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CFG_W-1:0]  cfg_rdata,
    input logic              acc_req,
    input logic              acc_write,
    input logic              acc_bank,
    input logic [IDX_W-1:0]  acc_index,
    input logic              ram_we,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              rd_done
);
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[CFG_W-1:POS_UPPER_LOCK+1] == '0 && cfg_rdata[POS_UPPER_EN-1:0] == '0);

    a_r3_lower_window_no_write: assert property (@(posedge clk) disable iff (rst)
        (ram_we && !acc_bank && in_window(acc_index)) |-> !cfg_rdata[POS_LOWER_LOCK]);

    a_r4_upper_window_no_write: assert property (@(posedge clk) disable iff (rst)
        (ram_we && acc_bank && in_window(acc_index)) |-> !cfg_rdata[POS_UPPER_LOCK]);

    a_r5_upper_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_rdata[POS_UPPER_LOCK]) |-> cfg_rdata[POS_UPPER_LOCK]);

    a_r5_lower_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_rdata[POS_LOWER_LOCK]) |-> cfg_rdata[POS_LOWER_LOCK]);

    a_r6_disabled_bank_no_write: assert property (@(posedge clk) disable iff (rst)
        (ram_we && acc_bank) |-> cfg_rdata[POS_UPPER_EN]);

    a_r8_write_needs_request: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (acc_req && acc_write));

    a_r10_done_follows_read: assert property (@(posedge clk) disable iff (rst)
        (acc_req && !acc_write) |=> rd_done);

    a_r10_done_only_after_read: assert property (@(posedge clk) disable iff (rst)
        !(acc_req && !acc_write) |=> !rd_done);

    a_r10_invalid_fill: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> rd_data == FILL_BYTE);
endmodule

bind rtcl_ram_guard rtcl_guard_checker u_chk (.*);

// File: tb/tb_rtcl_ram_guard.sv
module tb_rtcl_ram_guard;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_req = 1'b0, acc_write = 1'b0, acc_bank = 1'b0;
    logic [6:0]  acc_index = '0;
    logic [7:0]  acc_wdata = '0;
    logic        ram_we;
    logic [7:0]  ram_addr, ram_wdata, ram_rdata, rd_data;
    logic        rd_valid, rd_done;
    logic [7:0]  mem [256];
    int          n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    rtcl_ram_guard dut (.*);

    assign ram_rdata = mem[ram_addr];
    always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic do_cfg(input logic [31:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic do_write(input logic b, input logic [6:0] i, input logic [7:0] d, output logic we);
        @(negedge clk);
        acc_req = 1'b1; acc_write = 1'b1; acc_bank = b; acc_index = i; acc_wdata = d;
        #1 we = ram_we;
        @(negedge clk); acc_req = 1'b0; acc_write = 1'b0;
    endtask

    task automatic do_read(input logic b, input logic [6:0] i, output logic [7:0] d, output logic v, output logic dn);
        @(negedge clk);
        acc_req = 1'b1; acc_write = 1'b0; acc_bank = b; acc_index = i;
        @(negedge clk);
        acc_req = 1'b0;
        d = rd_data; v = rd_valid; dn = rd_done;
    endtask

    task automatic expect_write(input logic b, input logic [6:0] i, input logic [7:0] d, input logic exp_we, input string req);
        logic we;
        do_write(b, i, d, we);
        check(we == exp_we, req, {31'd0, we}, {31'd0, exp_we});
        if (exp_we) check(mem[{b, i}] == d, req, {24'd0, mem[{b, i}]}, {24'd0, d});
    endtask

    task automatic expect_read(input logic b, input logic [6:0] i, input logic exp_v, input logic [7:0] exp_d, input string req);
        logic [7:0] d; logic v, dn;
        do_read(b, i, d, v, dn);
        check(dn, req, {31'd0, dn}, 32'd1);
        check(v == exp_v, req, {31'd0, v}, {31'd0, exp_v});
        check(d == exp_d, req, {24'd0, d}, {24'd0, exp_d});
    endtask

    task automatic t_reset();
        #1;
        check(cfg_rdata == 32'h0, "R1", cfg_rdata, 32'h0);
        check(!rd_valid && !rd_done, "R1", {30'd0, rd_valid, rd_done}, 32'h0);
        check(rd_data == 8'hFF, "R1", {24'd0, rd_data}, 32'hFF);
    endtask

    task automatic t_passthrough();
        do_cfg(32'h4);
        expect_write(1'b0, 7'h10, 8'hA5, 1'b1, "R8");
        expect_write(1'b1, 7'h3A, 8'h5C, 1'b1, "R8");
        expect_write(1'b0, 7'h38, 8'h11, 1'b1, "R8");
        expect_write(1'b1, 7'h3C, 8'h22, 1'b1, "R8");
        expect_read(1'b0, 7'h10, 1'b1, 8'hA5, "R8");
        expect_read(1'b1, 7'h3A, 1'b1, 8'h5C, "R8");
        @(negedge clk);
        check(!rd_done && !rd_valid, "R10", {30'd0, rd_done, rd_valid}, 32'h0);
    endtask

    task automatic t_upper_off();
        do_cfg(32'h0);
        check(cfg_rdata == 32'h0, "R7", cfg_rdata, 32'h0);
        expect_write(1'b1, 7'h05, 8'h77, 1'b0, "R6");
        expect_read(1'b1, 7'h3A, 1'b0, 8'hFF, "R6");
        expect_read(1'b0, 7'h10, 1'b1, 8'hA5, "R6");
        do_cfg(32'h4);
        check(cfg_rdata == 32'h4, "R7", cfg_rdata, 32'h4);
        expect_read(1'b1, 7'h3A, 1'b1, 8'h5C, "R7");
    endtask

    task automatic t_lower_lock();
        do_cfg(32'hC);
        check(cfg_rdata == 32'hC, "R3", cfg_rdata, 32'hC);
        expect_write(1'b0, 7'h38, 8'hEE, 1'b0, "R3");
        expect_write(1'b0, 7'h3F, 8'hEE, 1'b0, "R3");
        expect_read(1'b0, 7'h38, 1'b0, 8'hFF, "R3");
        expect_write(1'b0, 7'h37, 8'h37, 1'b1, "R9");
        expect_write(1'b0, 7'h40, 8'h40, 1'b1, "R9");
        expect_write(1'b1, 7'h38, 8'h38, 1'b1, "R9");
        expect_read(1'b1, 7'h38, 1'b1, 8'h38, "R9");
    endtask

    task automatic t_sticky();
        do_cfg(32'h4);
        check(cfg_rdata == 32'hC, "R5", cfg_rdata, 32'hC);
        do_cfg(32'h0);
        check(cfg_rdata == 32'h8, "R7", cfg_rdata, 32'h8);
    endtask

    task automatic t_upper_lock();
        do_cfg(32'h14);
        check(cfg_rdata == 32'h1C, "R4", cfg_rdata, 32'h1C);
        expect_write(1'b1, 7'h3C, 8'h99, 1'b0, "R4");
        expect_read(1'b1, 7'h3C, 1'b0, 8'hFF, "R4");
        expect_write(1'b1, 7'h30, 8'h30, 1'b1, "R9");
    endtask

    task automatic t_reserved();
        do_cfg(32'hFFFF_FFE3);
        check(cfg_rdata == 32'h18, "R2", cfg_rdata, 32'h18);
    endtask

    task automatic t_reset_clears();
        do_reset();
        #1 check(cfg_rdata == 32'h0, "R5", cfg_rdata, 32'h0);
        do_cfg(32'h4);
        expect_read(1'b0, 7'h38, 1'b1, 8'h11, "R3");
        expect_read(1'b0, 7'h3F, 1'b1, 8'h00, "R3");
        expect_read(1'b1, 7'h3C, 1'b1, 8'h22, "R4");
    endtask

    initial begin
        for (int k = 0; k < 256; k++) mem[k] = 8'h00;
        do_reset();
        t_reset();
        t_passthrough();
        t_upper_off();
        t_lower_lock();
        t_sticky();
        t_upper_lock();
        t_reserved();
        t_reset_clears();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule